// File: doc/BRIEF.md
# Single-Position Shift Unit with Rotate Mode

This block is a combinational shifter for an n-bit operand. A 3-bit operation code selects one of several one-place moves of the operand: logical right or left, arithmetic right, rotate right or rotate left, or a straight pass-through. The top bit of the code turns the left and right paths from fill mode into rotate mode. The low two bits pick the direction, and for fill mode they also pick the fill type.

Alongside the result the block reports the bit that leaves the operand. It also has a result register that captures the shifted value on a step strobe. A datapath can feed that register back into the operand input to apply a chain of one-place moves, one per cycle.

Top module: `shift_uop_unit`

## Requirements
- R1: When the low two code bits are 00 (codes 000 and 100), `f_o` equals `a_i` and `spill_o` is 0.
- R2: Code 001 is a logical right shift: `f_o[W-1]` is 0, `f_o[i]` = `a_i[i+1]` for the other bits, and `spill_o` = `a_i[0]`.
- R3: Code 010 is a logical left shift: `f_o[0]` is 0, `f_o[i]` = `a_i[i-1]` for the other bits, and `spill_o` = `a_i[W-1]`.
- R4: Code 011 is an arithmetic right shift: `f_o[W-1]` = `a_i[W-1]`, the lower bits shift down one place, and `spill_o` = `a_i[0]`.
- R5: Code 101 is a rotate right: `f_o[W-1]` = `a_i[0]`, the lower bits shift down one place, and `spill_o` = `a_i[0]`.
- R6: Code 110 is a rotate left: `f_o[0]` = `a_i[W-1]`, the upper bits shift up one place, and `spill_o` = `a_i[W-1]`.
- R7: Code 111 passes `a_i` to `f_o` unchanged, and `spill_o` is 0.
- R8: While `rst_n` is low, `acc_o` is 0. On a rising clock edge with `step_i` high, `acc_o` takes the current `f_o`. With `step_i` low, it holds its value.
- R9: The width `W` is a parameter with default 8 and minimum 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the result register |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_i | input | W | Operand |
| sel_i | input | 3 | Operation code |
| step_i | input | 1 | Capture `f_o` into the result register |
| f_o | output | W | Shifted result |
| spill_o | output | 1 | Bit moved out of the operand, or 0 for pass codes |
| acc_o | output | W | Result register |

## Verification
The bench uses operands such as 0x81 and 0xB5, which have both end bits set, so that a fill of 0, a sign copy and a wrapped bit each give a different top or bottom bit. A design that mixes up fill and rotate, or arithmetic and logical right shift, gets exactly one end bit wrong. Code 111 and code 100 are checked against pass-through: a decoder that ignores the top code bit would shift on 111, and one that uses the top bit for 100 would alter the operand. The register is stepped through a chain of rotations and then held, to catch a design that captures the value without the strobe or captures it one cycle late.

// File: rtl/shift_uop_unit.sv
module shift_uop_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_i,
  input  logic [2:0]   sel_i,
  input  logic         step_i,
  output logic [W-1:0] f_o,
  output logic         spill_o,
  output logic [W-1:0] acc_o
);
  logic         rotate;
  logic         go_right;
  logic         go_left;
  logic         right_fill;
  logic         left_fill;
  logic [W-1:0] right_v;
  logic [W-1:0] left_v;

  assign rotate   = sel_i[2];
  assign go_right = (sel_i[1:0] == 2'b01) || (sel_i[1:0] == 2'b11 && !rotate);
  assign go_left  = (sel_i[1:0] == 2'b10);

  assign right_fill = rotate ? a_i[0] : (sel_i[1] & a_i[W-1]);
  assign left_fill  = rotate & a_i[W-1];

  assign right_v = {right_fill, a_i[W-1:1]};
  assign left_v  = {a_i[W-2:0], left_fill};

  always_comb begin
    if (go_right) begin
      f_o     = right_v;
      spill_o = a_i[0];
    end else if (go_left) begin
      f_o     = left_v;
      spill_o = a_i[W-1];
    end else begin
      f_o     = a_i;
      spill_o = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      acc_o <= '0;
    else if (step_i)
      acc_o <= f_o;
  end
endmodule

module shift_uop_unit_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_i,
  input logic [2:0]   sel_i,
  input logic         step_i,
  input logic [W-1:0] f_o,
  input logic         spill_o,
  input logic [W-1:0] acc_o
);
  assert_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i[1:0] == 2'b00) |-> (f_o == a_i && !spill_o));

  assert_lsr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == 3'b001) |-> (!f_o[W-1] && f_o[W-2:0] == a_i[W-1:1] && spill_o == a_i[0]));

  assert_lsl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == 3'b010) |-> (!f_o[0] && f_o[W-1:1] == a_i[W-2:0] && spill_o == a_i[W-1]));

  assert_asr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == 3'b011) |-> (f_o[W-1] == a_i[W-1] && f_o[W-2:0] == a_i[W-1:1]));

  assert_ror_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == 3'b101) |-> (f_o[W-1] == a_i[0] && f_o[W-2:0] == a_i[W-1:1]));

  assert_rol_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == 3'b110) |-> (f_o[0] == a_i[W-1] && f_o[W-1:1] == a_i[W-2:0]));

  assert_code7_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == 3'b111) |-> (f_o == a_i && !spill_o));

  assert_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> (acc_o == $past(f_o)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(acc_o));

  initial assert_width_R9: assert (W >= 2);
endmodule

bind shift_uop_unit shift_uop_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_i(a_i), .sel_i(sel_i), .step_i(step_i),
  .f_o(f_o), .spill_o(spill_o), .acc_o(acc_o)
);

// File: tb/tb_shift_uop_unit.sv
module tb_shift_uop_unit;
  localparam int W = 8;
  localparam int NV = 18;
  // each entry: {sel[2:0], a[7:0], f[7:0], spill}
  localparam logic [19:0] VEC [NV] = '{
    {3'b000, 8'hB5, 8'hB5, 1'b0},
    {3'b001, 8'hB5, 8'h5A, 1'b1},
    {3'b010, 8'hB5, 8'h6A, 1'b1},
    {3'b011, 8'hB5, 8'hDA, 1'b1},
    {3'b100, 8'hB5, 8'hB5, 1'b0},
    {3'b101, 8'hB5, 8'hDA, 1'b1},
    {3'b110, 8'hB5, 8'h6B, 1'b1},
    {3'b111, 8'hB5, 8'hB5, 1'b0},
    {3'b001, 8'h4A, 8'h25, 1'b0},
    {3'b010, 8'h4A, 8'h94, 1'b0},
    {3'b011, 8'h4A, 8'h25, 1'b0},
    {3'b101, 8'h4A, 8'h25, 1'b0},
    {3'b110, 8'h4A, 8'h94, 1'b0},
    {3'b011, 8'h81, 8'hC0, 1'b1},
    {3'b101, 8'h81, 8'hC0, 1'b1},
    {3'b110, 8'h81, 8'h03, 1'b1},
    {3'b010, 8'h81, 8'h02, 1'b1},
    {3'b001, 8'h81, 8'h40, 1'b1}
  };

  logic         clk = 0;
  logic         rst_n = 0;
  logic [W-1:0] a_i = '0;
  logic [2:0]   sel_i = '0;
  logic         step_i = 0;
  logic [W-1:0] f_o;
  logic         spill_o;
  logic [W-1:0] acc_o;
  int applied = 0;
  int bad = 0;
  bit done = 0;

  shift_uop_unit #(.W(W)) dut (.*);

  always #10 clk = ~clk;

  function automatic logic [W:0] model(input logic [2:0] s, input logic [W-1:0] a);
    logic [W-1:0] r = a;
    logic         sp = 1'b0;
    case (s)
      3'b001: begin r = a >> 1;                       sp = a[0];   end
      3'b010: begin r = a << 1;                       sp = a[W-1]; end
      3'b011: begin r = (a >> 1) | (a & (1 << (W-1))); sp = a[0];   end
      3'b101: begin r = (a >> 1) | ({{(W-1){1'b0}}, a[0]} << (W-1)); sp = a[0]; end
      3'b110: begin r = (a << 1) | {{(W-1){1'b0}}, a[W-1]}; sp = a[W-1]; end
      default: ;
    endcase
    return {sp, r};
  endfunction

  function automatic string tag(input logic [2:0] s);
    case (s)
      3'b001: return "R2";
      3'b010: return "R3";
      3'b011: return "R4";
      3'b101: return "R5";
      3'b110: return "R6";
      3'b111: return "R7";
      default: return "R1";
    endcase
  endfunction

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] s, input logic [W-1:0] a, input logic [W:0] exp);
    @(negedge clk);
    sel_i = s;
    a_i   = a;
    #1;
    check(tag(s), {spill_o, f_o}, exp);
  endtask

  initial begin
    #1;
    check("R8 reset", {1'b0, acc_o}, '0);
    repeat (2) @(negedge clk);
    rst_n = 1;

    for (int i = 0; i < NV; i++)
      apply(VEC[i][19:17], VEC[i][16:9], {VEC[i][0], VEC[i][8:1]});

    for (int i = 0; i < 200; i++) begin
      logic [2:0]   s = 3'($urandom);
      logic [W-1:0] a = W'($urandom);
      apply(s, a, model(s, a));
    end

    apply(3'b011, 8'hFF, {1'b1, 8'hFF});
    apply(3'b110, 8'h00, {1'b0, 8'h00});
    apply(3'b100, 8'h01, {1'b0, 8'h01});

    // R8: step captures, hold keeps
    @(negedge clk);
    a_i = 8'h81; sel_i = 3'b110; step_i = 1;
    @(negedge clk);
    check("R8 step", {1'b0, acc_o}, {1'b0, 8'h03});
    a_i = acc_o;
    @(negedge clk);
    check("R8 chain", {1'b0, acc_o}, {1'b0, 8'h06});
    step_i = 0; a_i = 8'hF0;
    @(negedge clk);
    @(negedge clk);
    check("R8 hold", {1'b0, acc_o}, {1'b0, 8'h06});
    rst_n = 0;
    #1;
    check("R8 async reset", {1'b0, acc_o}, '0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      applied++;
      bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end
endmodule